// File: doc/BRIEF.md
# Dual-Level Priority Bus Arbiter

This block decides which of three masters owns a shared memory bus: a display engine, a graphics engine and an external host. The display and graphics engines each carry two programmable 3-bit levels. One level applies when the engine opens a new request. The other applies while it is continuing a block transfer, which the engine marks with a continuation flag. Level 7 is the strongest and level 0 the weakest.

The host has a standard level and an alternate level. A free-running interval timer raises the host to its alternate level at fixed intervals. The host drops back to its standard level only after one of its slave bus cycles has executed. This bounds how long the host can be starved by a high-priority display engine. Programming the alternate level equal to the standard level turns the mechanism off.

A grant is decided when the bus is idle or when the current owner signals the end of its cycle. It is then held until that owner's cycle ends. Bus cycle timing itself is handled outside the block.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset, no grant is active (grant = 000) and host_eff_pri equals host_std_pri.
- R2: The grant vector (bit 0 host, bit 1 display, bit 2 graphics) has at most one bit set. A bit is set only for a requester whose request line was high on the arbitration edge.
- R3: A new decision is taken on a rising edge only when grant is 000 or cycle_done is high. Otherwise the grant is held unchanged.
- R4: On an arbitration edge, the requester with the numerically highest effective level is granted (7 highest, 0 lowest).
- R5: When the highest effective levels are equal, the host wins over the display engine, and the display engine wins over the graphics engine.
- R6: The effective level of the display or graphics engine is its continuation level when its continuation flag is 1, and its first-request level when the flag is 0.
- R7: The interval timer runs from reset and keeps counting whether or not the host is boosted. The host becomes boosted on the 42nd rising edge after reset and on every 42nd edge after that.
- R8: host_eff_pri equals host_alt_pri while the host is boosted and host_std_pri otherwise. The boost is cleared on an edge where host_slave_done is high, unless that edge is also an interval edge, in which case the host stays boosted.
- R9: When host_alt_pri equals host_std_pri, host_eff_pri equals host_std_pri at all times, so the boost has no effect on arbitration.
- R10: If no request line is high on an arbitration edge, grant becomes 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_host | input | 1 | Host requests the bus |
| req_disp | input | 1 | Display engine requests the bus |
| req_gfx | input | 1 | Graphics engine requests the bus |
| disp_cont | input | 1 | Display request continues a block transfer |
| gfx_cont | input | 1 | Graphics request continues a block transfer |
| cycle_done | input | 1 | Current owner finishes its bus cycle |
| host_slave_done | input | 1 | A host slave bus cycle has executed |
| disp_first_pri | input | 3 | Display first-request level |
| disp_cont_pri | input | 3 | Display continuation level |
| gfx_first_pri | input | 3 | Graphics first-request level |
| gfx_cont_pri | input | 3 | Graphics continuation level |
| host_std_pri | input | 3 | Host standard level |
| host_alt_pri | input | 3 | Host alternate (boost) level |
| grant | output | 3 | One-hot grant: bit 0 host, bit 1 display, bit 2 graphics |
| host_eff_pri | output | 3 | Host level currently used in arbitration |

## Verification
The hardest case to reach is a host slave cycle that lands on the very edge where the interval timer fires. From the ports this edge is visible only by counting clocks from reset. The bench's reference model tracks the interval phase itself and forces host_slave_done high on that exact cycle during the boost phase, alongside random slave pulses at other times. The other phases sweep priorities under random request mixes: ties with all levels equal, mixed continuation flags, sparse cycle_done to stress the hold rule, and idle bus gaps.

// File: rtl/arb_pkg.sv
package arb_pkg;
   localparam int unsigned NREQ     = 3;
   localparam int unsigned IDX_HOST = 0;
   localparam int unsigned IDX_DISP = 1;
   localparam int unsigned IDX_GFX  = 2;
endpackage

// File: rtl/arb_interval_timer.sv
module arb_interval_timer #(
   parameter int unsigned PERIOD = 42
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("arb_interval_timer: PERIOD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);

   // R7
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R7
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/arb_host_boost.sv
module arb_host_boost #(
   parameter int unsigned PRIO_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              slave_done,
   input  logic [PRIO_W-1:0] std_pri,
   input  logic [PRIO_W-1:0] alt_pri,
   output logic [PRIO_W-1:0] eff_pri
);
   logic boosted;

   always_ff @(posedge clk) begin
      if (!rst_n)          boosted <= 1'b0;
      else if (tick)       boosted <= 1'b1;
      else if (slave_done) boosted <= 1'b0;
   end

   assign eff_pri = boosted ? alt_pri : std_pri;

   // R7
   boost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> boosted);

   // R8
   boost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_done && !tick) |=> !boosted);

   // R8
   boost_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boosted && !slave_done) |=> boosted);
endmodule

// File: rtl/arb_level_sel.sv
module arb_level_sel #(
   parameter int unsigned PRIO_W = 3
) (
   input  logic              cont,
   input  logic [PRIO_W-1:0] first_pri,
   input  logic [PRIO_W-1:0] cont_pri,
   output logic [PRIO_W-1:0] eff_pri
);
   assign eff_pri = cont ? cont_pri : first_pri;
endmodule

// File: rtl/arb_pick.sv
module arb_pick
   import arb_pkg::*;
#(
   parameter int unsigned PRIO_W = 3
) (
   input  logic [NREQ-1:0]   req,
   input  logic [PRIO_W-1:0] pri [NREQ],
   output logic [NREQ-1:0]   win
);
   logic [PRIO_W-1:0] best;
   logic              found;

   always_comb begin
      win   = '0;
      best  = '0;
      found = 1'b0;
      for (int i = 0; i < NREQ; i++) begin
         if (req[i] && (!found || pri[i] > best)) begin
            found = 1'b1;
            best  = pri[i];
            win   = '0;
            win[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
   import arb_pkg::*;
#(
   parameter int unsigned PRIO_W = 3,
   parameter int unsigned PERIOD = 42
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_host,
   input  logic              req_disp,
   input  logic              req_gfx,
   input  logic              disp_cont,
   input  logic              gfx_cont,
   input  logic              cycle_done,
   input  logic              host_slave_done,
   input  logic [PRIO_W-1:0] disp_first_pri,
   input  logic [PRIO_W-1:0] disp_cont_pri,
   input  logic [PRIO_W-1:0] gfx_first_pri,
   input  logic [PRIO_W-1:0] gfx_cont_pri,
   input  logic [PRIO_W-1:0] host_std_pri,
   input  logic [PRIO_W-1:0] host_alt_pri,
   output logic [NREQ-1:0]   grant,
   output logic [PRIO_W-1:0] host_eff_pri
);
   generate
      if (PRIO_W < 1) begin : g_bad_width
         $error("prio_bus_arbiter: PRIO_W must be at least 1");
      end
   endgenerate

   logic [NREQ-1:0]   req;
   logic [NREQ-1:0]   cont_vec;
   logic [PRIO_W-1:0] first_arr [NREQ];
   logic [PRIO_W-1:0] cont_arr  [NREQ];
   logic [PRIO_W-1:0] eff       [NREQ];
   logic [NREQ-1:0]   win;
   logic              tick;
   logic              arb_en;

   assign req[IDX_HOST]       = req_host;
   assign req[IDX_DISP]       = req_disp;
   assign req[IDX_GFX]        = req_gfx;
   assign cont_vec[IDX_HOST]  = 1'b0;
   assign cont_vec[IDX_DISP]  = disp_cont;
   assign cont_vec[IDX_GFX]   = gfx_cont;
   assign first_arr[IDX_HOST] = '0;
   assign first_arr[IDX_DISP] = disp_first_pri;
   assign first_arr[IDX_GFX]  = gfx_first_pri;
   assign cont_arr[IDX_HOST]  = '0;
   assign cont_arr[IDX_DISP]  = disp_cont_pri;
   assign cont_arr[IDX_GFX]   = gfx_cont_pri;

   arb_interval_timer #(.PERIOD(PERIOD)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   arb_host_boost #(.PRIO_W(PRIO_W)) u_boost (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .slave_done(host_slave_done),
      .std_pri   (host_std_pri),
      .alt_pri   (host_alt_pri),
      .eff_pri   (host_eff_pri)
   );

   assign eff[IDX_HOST] = host_eff_pri;

   genvar gi;
   generate
      for (gi = 1; gi < NREQ; gi++) begin : g_engine
         arb_level_sel #(.PRIO_W(PRIO_W)) u_sel (
            .cont     (cont_vec[gi]),
            .first_pri(first_arr[gi]),
            .cont_pri (cont_arr[gi]),
            .eff_pri  (eff[gi])
         );
      end
   endgenerate

   arb_pick #(.PRIO_W(PRIO_W)) u_pick (
      .req(req),
      .pri(eff),
      .win(win)
   );

   assign arb_en = (grant == '0) || cycle_done;

   always_ff @(posedge clk) begin
      if (!rst_n)      grant <= '0;
      else if (arb_en) grant <= win;
   end

   // R2
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R2
   grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arb_en |=> ((grant & $past(req)) == grant));

   // R3
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0 && !cycle_done) |=> $stable(grant));

   // R10
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_en && req == '0) |=> grant == '0);

   // R9
   boost_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_alt_pri == host_std_pri) |-> host_eff_pri == host_std_pri);
endmodule

// File: tb/sim_prio_bus_arbiter.sv
module sim_prio_bus_arbiter;
   localparam int PER = 42;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic       req_host = 0, req_disp = 0, req_gfx = 0;
   logic       disp_cont = 0, gfx_cont = 0, cycle_done = 0, host_slave_done = 0;
   logic [2:0] disp_first_pri = 0, disp_cont_pri = 0, gfx_first_pri = 0, gfx_cont_pri = 0;
   logic [2:0] host_std_pri = 3'd3, host_alt_pri = 3'd6;
   logic [2:0] grant, host_eff_pri;

   prio_bus_arbiter u0 (
      .clk(clk), .rst_n(rst_n),
      .req_host(req_host), .req_disp(req_disp), .req_gfx(req_gfx),
      .disp_cont(disp_cont), .gfx_cont(gfx_cont),
      .cycle_done(cycle_done), .host_slave_done(host_slave_done),
      .disp_first_pri(disp_first_pri), .disp_cont_pri(disp_cont_pri),
      .gfx_first_pri(gfx_first_pri), .gfx_cont_pri(gfx_cont_pri),
      .host_std_pri(host_std_pri), .host_alt_pri(host_alt_pri),
      .grant(grant), .host_eff_pri(host_eff_pri)
   );

   int vectors = 0;
   int miscompares = 0;
   int m_cnt = 0;
   bit m_boost = 0;
   logic [2:0] m_grant = 3'b000;
   string tag = "R1";

   task automatic check(string r, logic [3:0] act, logic [3:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   function automatic logic [2:0] model_pick();
      int lv [3];
      bit rq [3];
      int best = -1;
      logic [2:0] w = 3'b000;
      rq[0] = req_host; rq[1] = req_disp; rq[2] = req_gfx;
      lv[0] = m_boost ? int'(host_alt_pri) : int'(host_std_pri);
      lv[1] = disp_cont ? int'(disp_cont_pri) : int'(disp_first_pri);
      lv[2] = gfx_cont ? int'(gfx_cont_pri) : int'(gfx_first_pri);
      for (int i = 0; i < 3; i++) begin
         if (rq[i] && lv[i] > best) begin
            best = lv[i];
            w = 3'b000;
            w[i] = 1'b1;
         end
      end
      return w;
   endfunction

   task automatic step_model();
      if (m_grant == 3'b000 || cycle_done) m_grant = model_pick();
      if (m_cnt == PER - 1) m_boost = 1;
      else if (host_slave_done) m_boost = 0;
      m_cnt = (m_cnt == PER - 1) ? 0 : m_cnt + 1;
   endtask

   task automatic compare();
      logic [2:0] exp_eff;
      exp_eff = m_boost ? host_alt_pri : host_std_pri;
      check(tag, {1'b0, grant}, {1'b0, m_grant});
      check(tag, {1'b0, host_eff_pri}, {1'b0, exp_eff});
      check("R2", {3'b000, $onehot0(grant)}, 4'd1);
   endtask

   task automatic drive();
      req_host = $urandom % 2; req_disp = $urandom % 2; req_gfx = $urandom % 2;
      disp_first_pri = $urandom; disp_cont_pri = $urandom;
      gfx_first_pri = $urandom; gfx_cont_pri = $urandom;
      host_std_pri = $urandom; host_alt_pri = host_std_pri;
      disp_cont = 0; gfx_cont = 0; cycle_done = 1; host_slave_done = 0;
      case (tag)
         "R5": begin
            disp_first_pri = $urandom;
            disp_cont_pri = disp_first_pri; gfx_first_pri = disp_first_pri;
            gfx_cont_pri = disp_first_pri; host_std_pri = disp_first_pri;
            host_alt_pri = disp_first_pri;
            disp_cont = $urandom % 2; gfx_cont = $urandom % 2;
         end
         "R6": begin
            disp_cont = $urandom % 2; gfx_cont = $urandom % 2;
         end
         "R3": begin
            disp_cont = $urandom % 2; gfx_cont = $urandom % 2;
            cycle_done = (($urandom % 4) == 0);
         end
         "R7": begin
            host_std_pri = 3'd0; host_alt_pri = 3'd7;
            cycle_done = $urandom % 2;
         end
         "R8": begin
            host_std_pri = $urandom % 4; host_alt_pri = 3'd4 + ($urandom % 4);
            cycle_done = $urandom % 2;
            host_slave_done = (($urandom % 6) == 0) || (m_cnt == PER - 1);
         end
         "R9": begin
            host_slave_done = $urandom % 2;
            cycle_done = $urandom % 2;
         end
         "R10": begin
            if ($urandom % 2) begin
               req_host = 0; req_disp = 0; req_gfx = 0;
            end
            cycle_done = $urandom % 2;
         end
         default: ;
      endcase
   endtask

   task automatic run(string t, int n);
      tag = t;
      repeat (n) begin
         @(negedge clk);
         compare();
         drive();
         step_model();
      end
   endtask

   initial begin
      #(20 * 200000);
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", {1'b0, grant}, 4'd0);
      check("R1", {1'b0, host_eff_pri}, {1'b0, host_std_pri});
      rst_n = 1'b1;
      drive();
      step_model();
      run("R4", 120);
      run("R5", 80);
      run("R6", 100);
      run("R3", 150);
      run("R7", 130);
      run("R8", 250);
      run("R9", 120);
      run("R10", 100);
      @(negedge clk);
      compare();
      summary();
   end
endmodule